// File: doc/BRIEF.md
# Watchdog Timer with Early Warning

This block guards a microcontroller subsystem against software that stops making progress. A counter advances on each pulse of a timebase enable. If software does not service it, the counter reaches a fixed timeout and the block raises a reset request for a fixed number of clocks. A little before that point it raises a warning flag. Software can use that flag to save state or log the event before the reset.

Software services the watchdog through a byte-wide write port. Writing the key byte 0xFF to the service register restarts the count. The status register holds two flags, and writing a zero to a flag's bit clears it. On overflow a sticky overflow bit is set. That bit is not touched by the reset request the block issues, so boot code can tell a watchdog recovery from a cold start. Only a software clear or the external reset input clears it. A falling edge on the wake input also clears the warning flag.

Top module: `wdog_top`

## Requirements
- R1: While `extRst` is high at a clock edge, the warning flag, the overflow bit and the reset request are all 0 after that edge, and the count returns to zero.
- R2: A write with `wrAddr`=0 and `wrData`=0xFF restarts the count. When no reset request is active, the next overflow follows exactly `TIMEOUT_TICKS` further timebase pulses.
- R3: A write to `wrAddr`=0 with any value other than 0xFF is ignored. It does not change the count or the time of the next overflow.
- R4: The warning flag is set by the timebase pulse that brings the count to `TIMEOUT_TICKS - WARN_LEAD` after a restart. The overflow follows `WARN_LEAD` pulses later.
- R5: A write with `wrAddr`=1 and `wrData[0]`=0 clears the warning flag. If `wrData[0]`=1, the flag is left unchanged.
- R6: A falling edge on `wake` (high in one cycle, low in the next) clears the warning flag once. Holding `wake` low does not clear a flag that is set later.
- R7: If a warning set and a clear (by software or by wake) fall on the same clock, the flag ends up set.
- R8: On overflow the overflow bit (`wrAddr`=1, bit 1) is set. `rstReq` goes high for exactly `RST_PULSE_CLKS` clocks. The count is zero once the pulse ends.
- R9: The overflow bit stays set through the reset request. Only a write with `wrAddr`=1 and `wrData[1]`=0, or `extRst`, clears it.
- R10: Timebase pulses and service writes that arrive while `rstReq` is high do not advance or restart the count. After the pulse, the next overflow comes after exactly `TIMEOUT_TICKS` further pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| extRst | input | 1 | External reset, synchronous, active high; also clears the overflow bit |
| tickEn | input | 1 | Timebase enable; each high cycle advances the count by one |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 1 | Register select: 0 = service, 1 = status |
| wrData | input | 8 | Write byte |
| wake | input | 1 | Wake input; a falling edge clears the warning flag |
| warnFlag | output | 1 | Early-warning flag |
| ovfStatus | output | 1 | Sticky overflow status |
| rstReq | output | 1 | Reset request pulse |

## Verification
The assertions take for granted that `extRst` is held high for at least two clocks. They also assume that `wrAddr`, `wrData`, `tickEn` and `wake` are stable around each clock edge, and that a reset pulse is never cut short except by `extRst`. The bench changes all inputs on the falling clock edge and opens with a multi-cycle reset. It lets every reset request run to its end before the next scenario. The one exception is the check of R1, where the bench asserts `extRst` in the middle of a pulse, and the pulse-length property is disabled during reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] SERVICE_KEY = 8'hFF;
  localparam logic ADDR_SERVICE = 1'b0;
  localparam logic ADDR_STATUS  = 1'b1;
  localparam int STAT_WARN_BIT = 0;
  localparam int STAT_OVF_BIT  = 1;

  typedef struct packed {
    logic restart;   // load count with zero
    logic advance;   // increment count by one
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_edge.sv
module wdog_edge (
  input  logic clk,
  input  logic extRst,
  input  logic sigIn,
  output logic fallPulse
);
  logic sigPrev;

  always_ff @(posedge clk) begin
    if (extRst) sigPrev <= 1'b0;
    else        sigPrev <= sigIn;
  end

  assign fallPulse = sigPrev & ~sigIn;
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1500,
  parameter int WARN_LEAD     = 1,
  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic             clk,
  input  logic             extRst,
  input  wdogStrobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             atTerminal,
  output logic             atWarnPoint
);
  localparam logic [CNT_W-1:0] TERMINAL  = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] WARNPOINT = CNT_W'(TIMEOUT_TICKS - WARN_LEAD - 1);

  always_ff @(posedge clk) begin
    if (extRst)              count <= '0;
    else if (strobe.restart) count <= '0;
    else if (strobe.advance) count <= count + 1'b1;
  end

  assign atTerminal  = (count == TERMINAL);
  assign atWarnPoint = (count == WARNPOINT);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int RST_PULSE_CLKS = 4,
  localparam int PULSE_W = $clog2(RST_PULSE_CLKS + 1)
) (
  input  logic              clk,
  input  logic              extRst,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wakeFall,
  input  logic              atTerminal,
  input  logic              atWarnPoint,
  output wdogStrobe_t       strobe,
  output logic              warnFlag,
  output logic              ovfStatus,
  output logic              rstReq
);
  logic [PULSE_W-1:0] pulseLeft;
  logic busy, serviceHit, statusWr, ovfEvent, warnEvent;
  logic warnClear, ovfClear;

  assign busy       = (pulseLeft != '0);
  assign serviceHit = wrEn && (wrAddr == ADDR_SERVICE) && (wrData == SERVICE_KEY) && !busy;
  assign statusWr   = wrEn && (wrAddr == ADDR_STATUS);
  assign warnClear  = (statusWr && !wrData[STAT_WARN_BIT]) || wakeFall;
  assign ovfClear   = statusWr && !wrData[STAT_OVF_BIT];

  always_comb begin
    strobe.advance = tickEn && !busy && !serviceHit;
    ovfEvent       = strobe.advance && atTerminal;
    warnEvent      = strobe.advance && atWarnPoint;
    strobe.restart = serviceHit || ovfEvent;
  end

  always_ff @(posedge clk) begin
    if (extRst)         pulseLeft <= '0;
    else if (ovfEvent)  pulseLeft <= PULSE_W'(RST_PULSE_CLKS);
    else if (busy)      pulseLeft <= pulseLeft - 1'b1;
  end

  // set wins over clear
  always_ff @(posedge clk) begin
    if (extRst)         warnFlag <= 1'b0;
    else if (warnEvent) warnFlag <= 1'b1;
    else if (warnClear) warnFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (extRst)        ovfStatus <= 1'b0;
    else if (ovfEvent) ovfStatus <= 1'b1;
    else if (ovfClear) ovfStatus <= 1'b0;
  end

  assign rstReq = busy;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS  = 1500,
  parameter int WARN_LEAD      = 1,
  parameter int RST_PULSE_CLKS = 4
) (
  input  logic       clk,
  input  logic       extRst,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [7:0] wrData,
  input  logic       wake,
  output logic       warnFlag,
  output logic       ovfStatus,
  output logic       rstReq
);
  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;

  wdogStrobe_t      strobe;
  logic [CNT_W-1:0] count;
  logic             atTerminal, atWarnPoint, wakeFall;

  wdog_edge u_wakeEdge (
    .clk(clk), .extRst(extRst), .sigIn(wake), .fallPulse(wakeFall)
  );

  wdog_datapath #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .WARN_LEAD(WARN_LEAD)) u_dp (
    .clk(clk), .extRst(extRst), .strobe(strobe), .count(count),
    .atTerminal(atTerminal), .atWarnPoint(atWarnPoint)
  );

  wdog_ctrl #(.RST_PULSE_CLKS(RST_PULSE_CLKS)) u_ctrl (
    .clk(clk), .extRst(extRst), .tickEn(tickEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .wakeFall(wakeFall),
    .atTerminal(atTerminal), .atWarnPoint(atWarnPoint), .strobe(strobe),
    .warnFlag(warnFlag), .ovfStatus(ovfStatus), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int TIMEOUT_TICKS  = 1500,
  parameter int WARN_LEAD      = 1,
  parameter int RST_PULSE_CLKS = 4,
  parameter int CNT_W          = 11
) (
  input logic             clk,
  input logic             extRst,
  input logic             tickEn,
  input logic             wrEn,
  input logic             wrAddr,
  input logic [7:0]       wrData,
  input logic             wake,
  input logic             warnFlag,
  input logic             ovfStatus,
  input logic             rstReq,
  input logic [CNT_W-1:0] count
);
  int highRun;
  logic wakeSeen;

  always_ff @(posedge clk) begin
    if (extRst)      highRun <= 0;
    else if (rstReq) highRun <= highRun + 1;
    else             highRun <= 0;
    wakeSeen <= extRst ? 1'b0 : wake;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    extRst |=> (!warnFlag && !ovfStatus && !rstReq && count == '0));

  assert_service_restart_R2: assert property (@(posedge clk) disable iff (extRst)
    (wrEn && !wrAddr && wrData == 8'hFF && !rstReq) |=> (count == '0));

  assert_ignore_write_R3: assert property (@(posedge clk) disable iff (extRst)
    (wrEn && !wrAddr && wrData != 8'hFF && !tickEn) |=> $stable(count));

  assert_warn_set_R4_R7: assert property (@(posedge clk) disable iff (extRst)
    (tickEn && !rstReq && !(wrEn && !wrAddr && wrData == 8'hFF)
     && count == CNT_W'(TIMEOUT_TICKS - WARN_LEAD - 1)) |=> warnFlag);

  assert_warn_clear_cause_R5_R6: assert property (@(posedge clk) disable iff (extRst)
    $fell(warnFlag) |-> $past((wrEn && wrAddr && !wrData[0]) || (wakeSeen && !wake)));

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (extRst)
    $fell(rstReq) |-> (highRun == RST_PULSE_CLKS));

  assert_ovf_on_pulse_R8: assert property (@(posedge clk) disable iff (extRst)
    $rose(rstReq) |-> ovfStatus);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (extRst)
    $fell(ovfStatus) |-> $past(wrEn && wrAddr && !wrData[1]));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (extRst)
    (rstReq && $past(rstReq)) |-> (count == '0));
endmodule

bind wdog_top wdog_checker #(
  .TIMEOUT_TICKS(TIMEOUT_TICKS), .WARN_LEAD(WARN_LEAD),
  .RST_PULSE_CLKS(RST_PULSE_CLKS), .CNT_W(CNT_W)
) u_wdogChecker (
  .clk(clk), .extRst(extRst), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .wake(wake), .warnFlag(warnFlag), .ovfStatus(ovfStatus),
  .rstReq(rstReq), .count(count)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;
  localparam int T = 6;
  localparam int W = 2;
  localparam int P = 3;

  logic clk = 1'b0;
  logic extRst = 1'b1;
  logic tickEn = 1'b0;
  logic wrEn = 1'b0;
  logic wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic wake = 1'b0;
  logic warnFlag, ovfStatus, rstReq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_top #(.TIMEOUT_TICKS(T), .WARN_LEAD(W), .RST_PULSE_CLKS(P)) i_wdog_top (
    .clk(clk), .extRst(extRst), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wake(wake), .warnFlag(warnFlag), .ovfStatus(ovfStatus),
    .rstReq(rstReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    tickEn = 1'b1; @(negedge clk); tickEn = 1'b0; @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d; @(negedge clk);
    wrEn = 1'b0; @(negedge clk);
  endtask

  task automatic clean();
    idle(P + 2);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hFF);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check(!warnFlag && !ovfStatus && !rstReq, "R1", {warnFlag, ovfStatus, rstReq}, 0);
    extRst = 1'b0;
    idle(1);

    // R2/R4: sweep pulse counts after a restart
    for (int n = 0; n <= T; n++) begin
      clean();
      for (int k = 0; k < n; k++) tick();
      check(warnFlag == (n >= T - W), "R4", warnFlag, int'(n >= T - W));
      check(rstReq == (n == T), "R2", rstReq, int'(n == T));
      check(ovfStatus == (n == T), "R8", ovfStatus, int'(n == T));
    end

    // R2: service mid-count postpones overflow
    clean();
    for (int k = 0; k < T - 1; k++) tick();
    wr(1'b0, 8'hFF);
    for (int k = 0; k < T - 1; k++) tick();
    check(!rstReq, "R2", rstReq, 0);
    tick();
    check(rstReq, "R2", rstReq, 1);

    // R3: every non-key value leaves the count alone
    for (int v = 0; v < 255; v++) begin
      clean();
      for (int k = 0; k < T - 1; k++) tick();
      wr(1'b0, 8'(v));
      tick();
      check(rstReq, "R3", rstReq, 1);
    end

    // R5: status write bit0
    clean();
    for (int k = 0; k < T - W; k++) tick();
    wr(1'b1, 8'h01);
    check(warnFlag, "R5", warnFlag, 1);
    wr(1'b1, 8'h02);
    check(!warnFlag, "R5", warnFlag, 0);

    // R6: wake fall clears once, level low does not clear again
    clean();
    wake = 1'b1; idle(2);
    for (int k = 0; k < T - W; k++) tick();
    check(warnFlag, "R6", warnFlag, 1);
    wake = 1'b0; idle(1);
    check(!warnFlag, "R6", warnFlag, 0);
    wr(1'b0, 8'hFF);
    for (int k = 0; k < T - W; k++) tick();
    idle(3);
    check(warnFlag, "R6", warnFlag, 1);

    // R7: set beats simultaneous software clear and wake fall
    clean();
    wake = 1'b1; idle(2);
    for (int k = 0; k < T - W - 1; k++) tick();
    tickEn = 1'b1; wrEn = 1'b1; wrAddr = 1'b1; wrData = 8'h00; wake = 1'b0;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    check(warnFlag, "R7", warnFlag, 1);

    // R8/R9/R10: pulse length, stickiness, ignored inputs while busy
    clean();
    tickEn = 1'b1;
    while (!rstReq) @(negedge clk);
    begin
      int hi = 0;
      int lo = 0;
      wrEn = 1'b1; wrAddr = 1'b0; wrData = 8'hFF;
      while (rstReq) begin hi++; @(negedge clk); end
      wrEn = 1'b0;
      check(hi == P, "R8", hi, P);
      check(ovfStatus, "R9", ovfStatus, 1);
      while (!rstReq) begin lo++; @(negedge clk); end
      check(lo == T, "R10", lo, T);
    end
    tickEn = 1'b0;
    idle(P + 1);
    wr(1'b1, 8'h02);
    check(ovfStatus, "R9", ovfStatus, 1);
    wr(1'b1, 8'h01);
    check(!ovfStatus, "R9", ovfStatus, 0);

    // R1/R9: external reset clears sticky bit mid-pulse
    wr(1'b0, 8'hFF);
    for (int k = 0; k < T; k++) tick();
    check(rstReq && ovfStatus, "R9", ovfStatus, 1);
    extRst = 1'b1; idle(2);
    check(!ovfStatus && !rstReq && !warnFlag, "R1", {warnFlag, ovfStatus, rstReq}, 0);
    extRst = 1'b0; idle(1);
    for (int k = 0; k < T; k++) tick();
    check(rstReq, "R1", rstReq, 1);

    idle(P + 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule